// File: doc/BRIEF.md
# Mesh Neighbour Operand Router

This block feeds each processing element of a lock-step array with the operand it takes from one of its neighbours. The whole array obeys a single broadcast instruction. That instruction names a direction (up, down, right or left) and an edge policy. The block takes the accumulator outputs of every element and returns one operand per element. An element at the edge of the mesh gets either zero or the value from the far end of its own row or column, as the edge policy selects.

The routing is purely combinational. It reads the registered accumulator values, so in any cycle every element sees the values from before that cycle's update. Elements are numbered in column order: the element at row `r` and column `c` has index `c*NUM_ROWS + r`. With `NUM_ROWS = 1` the block becomes a single row, and only horizontal movement is meaningful.

Top module: `meshOperandRouter`

## Requirements
- R1: With `dirSel` = 0 (north), element (r,c) with r > 0 receives the accumulator of element (r-1,c).
- R2: With `dirSel` = 3 (south), element (r,c) with r < NUM_ROWS-1 receives the accumulator of element (r+1,c).
- R3: With `dirSel` = 1 (east), element (r,c) with c < NUM_COLS-1 receives the accumulator of element (r,c+1).
- R4: With `dirSel` = 2 (west), element (r,c) with c > 0 receives the accumulator of element (r,c-1).
- R5: With `wrapEn` = 0, an element whose selected neighbour lies outside the mesh receives zero.
- R6: With `wrapEn` = 1, an element whose selected neighbour lies outside the mesh receives the accumulator of the element at the opposite end of the same row (east/west) or column (north/south).
- R7: Element (r,c) has index p = c*NUM_ROWS + r. Its accumulator occupies bits [p*DATA_W +: DATA_W] of `accFlat`, and its operand occupies the same bits of `operandFlat`.
- R8: When NUM_ROWS = 1, north and south give zero to every element in either edge mode.
- R9: A `dirSel` value of 4 to 7 gives zero to every element in either edge mode.
- R10: The block has no clock. A change on `accFlat`, `dirSel` or `wrapEn` appears on `operandFlat` with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| accFlat | input | NUM_ROWS*NUM_COLS*DATA_W | Registered accumulator of every element, packed by element index |
| dirSel | input | 3 | Direction code: 0 north, 1 east, 2 west, 3 south, 4-7 invalid |
| wrapEn | input | 1 | Edge policy: 0 zero fill, 1 wrap to the opposite end |
| operandFlat | output | NUM_ROWS*NUM_COLS*DATA_W | Routed operand of every element, packed by element index |

## Verification
The bench builds two copies of the router side by side. One is the default 4x4 mesh with 32-bit data. The other is a 1x8 row, which is the one-dimensional variant. The square mesh has interior elements, corners and every edge kind on both axes, so each direction can be checked under both edge policies together with the column-order numbering. The single row makes the vertical directions degenerate and exercises wraparound along a longer row.

// File: rtl/meshRoutePkg.sv
package meshRoutePkg;

  localparam logic [2:0] DIR_NORTH = 3'd0;
  localparam logic [2:0] DIR_EAST  = 3'd1;
  localparam logic [2:0] DIR_WEST  = 3'd2;
  localparam logic [2:0] DIR_SOUTH = 3'd3;

  typedef struct packed {
    logic takeNorth;
    logic takeEast;
    logic takeWest;
    logic takeSouth;
    logic wrapEdge;
  } routeStrobeT;

endpackage

// File: rtl/meshRouteCtrl.sv
module meshRouteCtrl
  import meshRoutePkg::*;
#(
  parameter int NUM_ROWS = 4
) (
  input  logic [2:0]  dirSel,
  input  logic        wrapEn,
  output routeStrobeT strobes
);

  localparam bit HAS_VERTICAL = (NUM_ROWS > 1);

  always_comb begin
    strobes = '0;
    strobes.wrapEdge = wrapEn;
    case (dirSel)
      DIR_NORTH: strobes.takeNorth = HAS_VERTICAL;
      DIR_EAST:  strobes.takeEast  = 1'b1;
      DIR_WEST:  strobes.takeWest  = 1'b1;
      DIR_SOUTH: strobes.takeSouth = HAS_VERTICAL;
      default:   strobes = '{default: 1'b0};
    endcase

    if (!$isunknown(dirSel) && !$isunknown(wrapEn)) begin
      // R9: at most one direction strobe, none for an invalid code
      a_r9_one_direction: assert ($onehot0({strobes.takeNorth, strobes.takeEast,
                                            strobes.takeWest, strobes.takeSouth}));
      if (dirSel > DIR_SOUTH) begin
        a_r9_invalid_idle: assert (!strobes.takeNorth && !strobes.takeEast &&
                                   !strobes.takeWest && !strobes.takeSouth);
      end
      if (NUM_ROWS == 1) begin
        a_r8_no_vertical: assert (!strobes.takeNorth && !strobes.takeSouth);
      end
    end
  end

endmodule

// File: rtl/meshRouteDatapath.sv
module meshRouteDatapath
  import meshRoutePkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4,
  parameter int DATA_W   = 32
) (
  input  logic [NUM_ROWS*NUM_COLS*DATA_W-1:0] accFlat,
  input  routeStrobeT                         strobes,
  output logic [NUM_ROWS*NUM_COLS*DATA_W-1:0] operandFlat
);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      localparam int  SELF_IDX = c * NUM_ROWS + r;
      localparam bit  NORTH_EDGE = (r == 0);
      localparam bit  SOUTH_EDGE = (r == NUM_ROWS - 1);
      localparam bit  EAST_EDGE  = (c == NUM_COLS - 1);
      localparam bit  WEST_EDGE  = (c == 0);
      localparam int  NORTH_ROW = NORTH_EDGE ? NUM_ROWS - 1 : r - 1;
      localparam int  SOUTH_ROW = SOUTH_EDGE ? 0 : r + 1;
      localparam int  EAST_COL  = EAST_EDGE ? 0 : c + 1;
      localparam int  WEST_COL  = WEST_EDGE ? NUM_COLS - 1 : c - 1;
      localparam int  NORTH_IDX = c * NUM_ROWS + NORTH_ROW;
      localparam int  SOUTH_IDX = c * NUM_ROWS + SOUTH_ROW;
      localparam int  EAST_IDX  = EAST_COL * NUM_ROWS + r;
      localparam int  WEST_IDX  = WEST_COL * NUM_ROWS + r;

      logic [DATA_W-1:0] fromNorth, fromSouth, fromEast, fromWest, pick;
      logic              hitEdge;

      assign fromNorth = accFlat[NORTH_IDX*DATA_W +: DATA_W];
      assign fromSouth = accFlat[SOUTH_IDX*DATA_W +: DATA_W];
      assign fromEast  = accFlat[EAST_IDX*DATA_W +: DATA_W];
      assign fromWest  = accFlat[WEST_IDX*DATA_W +: DATA_W];

      always_comb begin
        pick    = '0;
        hitEdge = 1'b0;
        if (strobes.takeNorth) begin
          hitEdge = NORTH_EDGE;
          pick    = fromNorth;
        end else if (strobes.takeSouth) begin
          hitEdge = SOUTH_EDGE;
          pick    = fromSouth;
        end else if (strobes.takeEast) begin
          hitEdge = EAST_EDGE;
          pick    = fromEast;
        end else if (strobes.takeWest) begin
          hitEdge = WEST_EDGE;
          pick    = fromWest;
        end
        if (hitEdge && !strobes.wrapEdge) pick = '0;

        if (!$isunknown(strobes) && !$isunknown(accFlat)) begin
          if (!(strobes.takeNorth || strobes.takeSouth ||
                strobes.takeEast || strobes.takeWest)) begin
            a_r9_no_strobe_zero: assert (pick == '0);
          end
          if (!strobes.wrapEdge && strobes.takeEast && c == NUM_COLS - 1) begin
            a_r5_east_edge_zero: assert (pick == '0);
          end
          if (strobes.wrapEdge && strobes.takeEast && c == NUM_COLS - 1) begin
            // R6: east wrap lands on column 0 of the same row
            a_r6_east_wrap_col0: assert (pick == accFlat[r*DATA_W +: DATA_W]);
          end
          if (strobes.wrapEdge && strobes.takeSouth && r == NUM_ROWS - 1) begin
            a_r6_south_wrap_row0: assert (pick == accFlat[(c*NUM_ROWS)*DATA_W +: DATA_W]);
          end
        end
      end

      assign operandFlat[SELF_IDX*DATA_W +: DATA_W] = pick;
    end
  end

endmodule

// File: rtl/meshOperandRouter.sv
module meshOperandRouter
  import meshRoutePkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int NUM_COLS = 4,
  parameter int DATA_W   = 32
) (
  input  logic [NUM_ROWS*NUM_COLS*DATA_W-1:0] accFlat,
  input  logic [2:0]                          dirSel,
  input  logic                                wrapEn,
  output logic [NUM_ROWS*NUM_COLS*DATA_W-1:0] operandFlat
);

  routeStrobeT strobes;

  meshRouteCtrl #(
    .NUM_ROWS(NUM_ROWS)
  ) ctrl_i (
    .dirSel (dirSel),
    .wrapEn (wrapEn),
    .strobes(strobes)
  );

  meshRouteDatapath #(
    .NUM_ROWS(NUM_ROWS),
    .NUM_COLS(NUM_COLS),
    .DATA_W  (DATA_W)
  ) path_i (
    .accFlat    (accFlat),
    .strobes    (strobes),
    .operandFlat(operandFlat)
  );

endmodule

// File: tb/meshOperandRouter_tb_top.sv
module meshOperandRouter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [16*DW-1:0] acc2d;
  logic [8*DW-1:0]  acc1d;
  logic [2:0]       dirSel;
  logic             wrapEn;
  logic [16*DW-1:0] op2d;
  logic [8*DW-1:0]  op1d;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  meshOperandRouter #(.NUM_ROWS(4), .NUM_COLS(4), .DATA_W(DW)) dut_i (
    .accFlat(acc2d), .dirSel(dirSel), .wrapEn(wrapEn), .operandFlat(op2d));

  meshOperandRouter #(.NUM_ROWS(1), .NUM_COLS(8), .DATA_W(DW)) dut1d_i (
    .accFlat(acc1d), .dirSel(dirSel), .wrapEn(wrapEn), .operandFlat(op1d));

  function automatic logic [DW-1:0] modelOp(int rows, int cols, int p,
                                            logic [2:0] dir, logic wrap,
                                            logic [16*DW-1:0] acc);
    int r, c, nr, nc;
    bit atEdge;
    r = p % rows;
    c = p / rows;
    nr = r;
    nc = c;
    atEdge = 1'b0;
    case (dir)
      3'd0: begin
        if (rows == 1) return '0;
        atEdge = (r == 0);
        nr = atEdge ? rows - 1 : r - 1;
      end
      3'd3: begin
        if (rows == 1) return '0;
        atEdge = (r == rows - 1);
        nr = atEdge ? 0 : r + 1;
      end
      3'd1: begin
        atEdge = (c == cols - 1);
        nc = atEdge ? 0 : c + 1;
      end
      3'd2: begin
        atEdge = (c == 0);
        nc = atEdge ? cols - 1 : c - 1;
      end
      default: return '0;
    endcase
    if (atEdge && !wrap) return '0;
    return acc[(nc*rows+nr)*DW +: DW];
  endfunction

  task automatic checkVal(string req, string what, logic [DW-1:0] actual,
                          logic [DW-1:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, actual, expected);
    end
  endtask

  task automatic applyAndSweep(string req, logic [2:0] dir, logic wrap);
    @(posedge clk);
    #1;
    dirSel = dir;
    wrapEn = wrap;
    @(negedge clk);
    for (int p = 0; p < 16; p++)
      checkVal(req, $sformatf("4x4 pe%0d dir%0d wrap%0d", p, dir, wrap),
               op2d[p*DW +: DW], modelOp(4, 4, p, dir, wrap, acc2d));
    for (int p = 0; p < 8; p++)
      checkVal(req, $sformatf("1x8 pe%0d dir%0d wrap%0d", p, dir, wrap),
               op1d[p*DW +: DW], modelOp(1, 8, p, dir, wrap, {{(8*DW){1'b0}}, acc1d}));
  endtask

  task automatic loadPattern(int seed);
    @(posedge clk);
    #1;
    for (int p = 0; p < 16; p++) acc2d[p*DW +: DW] = DW'(32'h0000_0100 + p*3 + seed*32'h1111_0000);
    for (int p = 0; p < 8; p++)  acc1d[p*DW +: DW] = DW'(32'h0000_0500 + p + seed*32'h0F0F_0000);
  endtask

  task automatic testIdle();
    acc2d = '0; acc1d = '0; dirSel = 3'd7; wrapEn = 1'b0;
    @(negedge clk);
    checkVal("R9", "idle 4x4 bus", op2d[DW-1:0], '0);
    checkVal("R9", "idle 1x8 bus", op1d[DW-1:0], '0);
  endtask

  task automatic testNorth();
    applyAndSweep("R1 R5", 3'd0, 1'b0);
    applyAndSweep("R1 R6", 3'd0, 1'b1);
  endtask

  task automatic testSouth();
    applyAndSweep("R2 R5", 3'd3, 1'b0);
    applyAndSweep("R2 R6", 3'd3, 1'b1);
  endtask

  task automatic testEast();
    applyAndSweep("R3 R5", 3'd1, 1'b0);
    applyAndSweep("R3 R6", 3'd1, 1'b1);
  endtask

  task automatic testWest();
    applyAndSweep("R4 R5", 3'd2, 1'b0);
    applyAndSweep("R4 R6", 3'd2, 1'b1);
  endtask

  task automatic testNumbering();
    // R7: only element 5 (row 1, col 1) nonzero; east feeds element 1 (row 1, col 0)
    @(posedge clk);
    #1;
    acc2d = '0;
    acc2d[5*DW +: DW] = 32'hCAFE_0005;
    dirSel = 3'd1;
    wrapEn = 1'b0;
    @(negedge clk);
    checkVal("R7", "east into pe1", op2d[1*DW +: DW], 32'hCAFE_0005);
    checkVal("R7", "east into pe4 stays zero", op2d[4*DW +: DW], '0);
    dirSel = 3'd0;
    @(negedge clk);
    checkVal("R7", "north into pe6", op2d[6*DW +: DW], 32'hCAFE_0005);
    checkVal("R7", "north into pe9 stays zero", op2d[9*DW +: DW], '0);
  endtask

  task automatic testOneD();
    for (int w = 0; w < 2; w++) begin
      applyAndSweep("R8", 3'd0, w[0]);
      applyAndSweep("R8", 3'd3, w[0]);
      for (int p = 0; p < 8; p++)
        checkVal("R8", $sformatf("1x8 south pe%0d", p), op1d[p*DW +: DW], '0);
    end
  endtask

  task automatic testInvalid();
    for (int d = 4; d < 8; d++) begin
      applyAndSweep("R9", d[2:0], 1'b1);
      applyAndSweep("R9", d[2:0], 1'b0);
    end
  endtask

  task automatic testComb();
    // R10: no clock edge between the input change and the sample
    @(negedge clk);
    dirSel = 3'd2;
    wrapEn = 1'b1;
    acc2d[15*DW +: DW] = 32'h1234_5678;
    #1;
    checkVal("R10", "west wrap into pe3", op2d[3*DW +: DW], 32'h1234_5678);
    acc2d[15*DW +: DW] = 32'h8765_4321;
    #1;
    checkVal("R10", "follows acc change", op2d[3*DW +: DW], 32'h8765_4321);
    wrapEn = 1'b0;
    #1;
    checkVal("R10", "follows mode change", op2d[3*DW +: DW], '0);
  endtask

  initial begin
    testIdle();
    loadPattern(0);
    testNorth();
    testSouth();
    testEast();
    testWest();
    loadPattern(7);
    testEast();
    testNorth();
    testNumbering();
    loadPattern(3);
    testOneD();
    testInvalid();
    testComb();
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < WATCHDOG_CYCLES; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule